// File: doc/BRIEF.md
# Paged Address and Bus-Source Unit

This unit is the address and bus-steering core of a small microcoded processor. It builds a 24-bit memory address from a 16-bit low address register and an 8-bit high address register. It keeps a stack pointer and an 8-bit stack page register. It also holds two instruction words: the primary one and a second word used by multi-word instructions. A shared 16-bit data bus is driven from exactly one source. The source is chosen by a 5-bit source code qualified by an enable bit.

The stack page register gives a pageable stack inside the 24-bit space. Whenever the stack pointer is the bus source while the low address register is latched, the page value is forced into the upper address byte. The sequencer supplies control-word strobes each cycle. Memory supplies a read word plus a hit flag. Any source code this unit does not own passes through an external data input. That input stands in for the register file, the program counter and the ALU.

Top module: `paged_addr_unit`

## Requirements
- R1: After reset the stack pointer is 0xFFFF, the stack page is 0xFF, the primary and second instruction words are 0, and the address bus is 0.
- R2: While `busEn` is low the data bus reads 0, whatever the source code.
- R3: Strobing `loadAddrHi` stores only bus bits [7:0] into the high register. The address bus always equals high register × 65536 + low register, and `loadAddrLo` stores the full 16-bit bus into the low register.
- R4: When code 5'b00001 (stack pointer) is selected with `busEn` high while `loadAddrLo` is strobed, address bits [23:16] take the stack page value. This overrides a simultaneous `loadAddrHi`.
- R5: Code 5'b11000 puts the memory word on the bus and captures it into the second instruction word at the rising edge.
- R6: Code 5'b11001 drives the second instruction word onto the bus.
- R7: Code 5'b11010 drives the high address register onto bus bits [7:0], with bits [15:8] at 0.
- R8: Code 5'b11011 puts the memory word on the bus and loads its bits [7:0] into the stack page at the rising edge.
- R9: Code 5'b11111 drives the memory word onto the bus. Every memory word the unit uses (codes 11000, 11011, 11111) reads as 0 when `memHit` is low.
- R10: `spInc` adds 1 and `spDec` subtracts 1 from the stack pointer at the rising edge, modulo 2^16. Both together leave it unchanged. Code 5'b00001 shows it on the bus.
- R11: Every other source code drives `extData` onto the bus.
- R12: `irLoad` stores the bus into the primary instruction word, presented on `instrWord`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busEn | input | 1 | Bus output enable |
| busSel | input | 5 | Bus source code |
| loadAddrLo | input | 1 | Latch bus into low address register |
| loadAddrHi | input | 1 | Latch bus low byte into high address register |
| spInc | input | 1 | Stack pointer increment strobe |
| spDec | input | 1 | Stack pointer decrement strobe |
| irLoad | input | 1 | Latch bus into primary instruction word |
| memRdData | input | 16 | Memory read word |
| memHit | input | 1 | Memory location holds written data |
| extData | input | 16 | Data from sources outside this unit |
| addrBus | output | 24 | Paged memory address |
| dataBus | output | 16 | Shared data bus |
| instrWord | output | 16 | Primary instruction word |

## Verification
The assertions watch, on every cycle, the invariants that relate one cycle to the next:
- the bus is idle when disabled;
- the page byte is substituted on a stack-pointer address latch;
- the high register keeps only the byte;
- the second instruction word and the page are captured from memory;
- the stack pointer steps by one.

Only the bench scenarios show the reset values and the full map of source codes to bus values. The bench sweeps all 32 codes with the enable both high and low. It also shows the stack pointer wrap through 0 and the zero reading of missed memory.

// File: rtl/paged_addr_pkg.sv
package paged_addr_pkg;
  parameter int LO_W   = 16;
  parameter int PAGE_W = 8;
  parameter int SEL_W  = 5;

  localparam logic [SEL_W-1:0] SRC_SP      = 5'b00001;
  localparam logic [SEL_W-1:0] SRC_MEM_IR2 = 5'b11000;
  localparam logic [SEL_W-1:0] SRC_IR2     = 5'b11001;
  localparam logic [SEL_W-1:0] SRC_HIGH    = 5'b11010;
  localparam logic [SEL_W-1:0] SRC_MEM_PG  = 5'b11011;
  localparam logic [SEL_W-1:0] SRC_MEM     = 5'b11111;

  typedef struct packed {
    logic driveSp;
    logic driveMem;
    logic driveIr2;
    logic driveHigh;
    logic driveExt;
    logic captureIr2;
    logic loadPage;
    logic pageSubst;
  } strobe_t;
endpackage

// File: rtl/paged_addr_ctrl.sv
module paged_addr_ctrl
  import paged_addr_pkg::*;
(
  input  logic             busEn,
  input  logic [SEL_W-1:0] busSel,
  input  logic             loadAddrLo,
  output strobe_t          strobes
);
  always_comb begin
    strobes = '0;
    if (busEn) begin
      unique case (busSel)
        SRC_SP:      strobes.driveSp = 1'b1;
        SRC_MEM_IR2: begin strobes.driveMem = 1'b1; strobes.captureIr2 = 1'b1; end
        SRC_IR2:     strobes.driveIr2 = 1'b1;
        SRC_HIGH:    strobes.driveHigh = 1'b1;
        SRC_MEM_PG:  begin strobes.driveMem = 1'b1; strobes.loadPage = 1'b1; end
        SRC_MEM:     strobes.driveMem = 1'b1;
        default:     strobes.driveExt = 1'b1;
      endcase
      strobes.pageSubst = (busSel == SRC_SP) && loadAddrLo;
    end
  end
endmodule

// File: rtl/paged_addr_datapath.sv
module paged_addr_datapath
  import paged_addr_pkg::*;
#(
  parameter int LoW   = LO_W,
  parameter int PageW = PAGE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  logic                  loadAddrLo,
  input  logic                  loadAddrHi,
  input  logic                  spInc,
  input  logic                  spDec,
  input  logic                  irLoad,
  input  logic [LoW-1:0]        memRdData,
  input  logic                  memHit,
  input  logic [LoW-1:0]        extData,
  output logic [LoW+PageW-1:0]  addrBus,
  output logic [LoW-1:0]        dataBus,
  output logic [LoW-1:0]        instrWord
);
  localparam int PadW = LoW - PageW;

  logic [LoW-1:0]   addrLo;
  logic [PageW-1:0] addrHi;
  logic [LoW-1:0]   spReg;
  logic [PageW-1:0] pageReg;
  logic [LoW-1:0]   ir2Reg;
  logic [LoW-1:0]   irReg;
  logic [LoW-1:0]   memWord;

  assign memWord = memHit ? memRdData : '0;

  always_comb begin
    dataBus = '0;
    if (strobes.driveSp)   dataBus = spReg;
    if (strobes.driveMem)  dataBus = memWord;
    if (strobes.driveIr2)  dataBus = ir2Reg;
    if (strobes.driveHigh) dataBus = {{PadW{1'b0}}, addrHi};
    if (strobes.driveExt)  dataBus = extData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo  <= '0;
      addrHi  <= '0;
      spReg   <= '1;
      pageReg <= '1;
      ir2Reg  <= '0;
      irReg   <= '0;
    end else begin
      if (loadAddrLo) addrLo <= dataBus;
      if (strobes.pageSubst)  addrHi <= pageReg;
      else if (loadAddrHi)    addrHi <= dataBus[PageW-1:0];
      if (spInc && !spDec)    spReg <= spReg + 1'b1;
      else if (spDec && !spInc) spReg <= spReg - 1'b1;
      if (strobes.loadPage)   pageReg <= memWord[PageW-1:0];
      if (strobes.captureIr2) ir2Reg <= memWord;
      if (irLoad)             irReg <= dataBus;
    end
  end

  assign addrBus   = {addrHi, addrLo};
  assign instrWord = irReg;
endmodule

// File: rtl/paged_addr_unit.sv
module paged_addr_unit
  import paged_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busEn,
  input  logic [4:0]  busSel,
  input  logic        loadAddrLo,
  input  logic        loadAddrHi,
  input  logic        spInc,
  input  logic        spDec,
  input  logic        irLoad,
  input  logic [15:0] memRdData,
  input  logic        memHit,
  input  logic [15:0] extData,
  output logic [23:0] addrBus,
  output logic [15:0] dataBus,
  output logic [15:0] instrWord
);
  strobe_t strobes;

  paged_addr_ctrl u_ctrl (
    .busEn(busEn), .busSel(busSel), .loadAddrLo(loadAddrLo), .strobes(strobes)
  );

  paged_addr_datapath #(.LoW(16), .PageW(8)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .loadAddrLo(loadAddrLo), .loadAddrHi(loadAddrHi),
    .spInc(spInc), .spDec(spDec), .irLoad(irLoad),
    .memRdData(memRdData), .memHit(memHit), .extData(extData),
    .addrBus(addrBus), .dataBus(dataBus), .instrWord(instrWord)
  );
endmodule

// File: rtl/paged_addr_checker.sv
module paged_addr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busEn,
  input logic [4:0]  busSel,
  input logic        loadAddrLo,
  input logic        loadAddrHi,
  input logic        spInc,
  input logic        spDec,
  input logic [15:0] memRdData,
  input logic        memHit,
  input logic [23:0] addrBus,
  input logic [15:0] dataBus,
  input logic [15:0] spVal,
  input logic [7:0]  pageVal,
  input logic [15:0] ir2Val
);
  logic subst;
  assign subst = busEn && (busSel == 5'b00001) && loadAddrLo;

  assert_bus_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |-> dataBus == 16'h0);

  assert_page_subst_R4: assert property (@(posedge clk) disable iff (!rstN)
    subst |=> addrBus[23:16] == $past(pageVal));

  assert_high_byte_R3: assert property (@(posedge clk) disable iff (!rstN)
    (loadAddrHi && !subst) |=> addrBus[23:16] == $past(dataBus[7:0]));

  assert_low_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    loadAddrLo |=> addrBus[15:0] == $past(dataBus));

  assert_ir2_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busSel == 5'b11000) |=> ir2Val == $past(dataBus));

  assert_page_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busSel == 5'b11011) |=> pageVal == $past(dataBus[7:0]));

  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busSel == 5'b11111 && !memHit) |-> dataBus == 16'h0);

  assert_sp_inc_R10: assert property (@(posedge clk) disable iff (!rstN)
    (spInc && !spDec) |=> spVal == $past(spVal) + 16'h1);

  assert_sp_dec_R10: assert property (@(posedge clk) disable iff (!rstN)
    (spDec && !spInc) |=> spVal == $past(spVal) - 16'h1);

  assert_sp_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (spDec == spInc) |=> $stable(spVal));
endmodule

bind paged_addr_unit paged_addr_checker u_chk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .busSel(busSel),
  .loadAddrLo(loadAddrLo), .loadAddrHi(loadAddrHi),
  .spInc(spInc), .spDec(spDec), .memRdData(memRdData), .memHit(memHit),
  .addrBus(addrBus), .dataBus(dataBus),
  .spVal(u_dp.spReg), .pageVal(u_dp.pageReg), .ir2Val(u_dp.ir2Reg)
);

// File: tb/paged_addr_unit_bench.sv
module paged_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0;
  logic [4:0]  busSel = '0;
  logic        loadAddrLo = 1'b0, loadAddrHi = 1'b0;
  logic        spInc = 1'b0, spDec = 1'b0, irLoad = 1'b0;
  logic [15:0] memRdData = '0;
  logic        memHit = 1'b0;
  logic [15:0] extData = '0;
  logic [23:0] addrBus;
  logic [15:0] dataBus;
  logic [15:0] instrWord;

  int total = 0;
  int bad = 0;
  logic [15:0] mIr2;
  logic [7:0]  mPage;
  logic [7:0]  mHigh;
  logic [15:0] mSp;

  always #10 clk = ~clk;

  paged_addr_unit u_paged_addr_unit (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busSel(busSel),
    .loadAddrLo(loadAddrLo), .loadAddrHi(loadAddrHi),
    .spInc(spInc), .spDec(spDec), .irLoad(irLoad),
    .memRdData(memRdData), .memHit(memHit), .extData(extData),
    .addrBus(addrBus), .dataBus(dataBus), .instrWord(instrWord)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic en, input logic [4:0] sel);
    busEn = en; busSel = sel;
    loadAddrLo = 0; loadAddrHi = 0; spInc = 0; spDec = 0; irLoad = 0;
  endtask

  function automatic logic [15:0] expBus(input logic [4:0] sel);
    logic [15:0] mw;
    mw = memHit ? memRdData : 16'h0;
    case (sel)
      5'b00001: return mSp;
      5'b11000, 5'b11011, 5'b11111: return mw;
      5'b11001: return mIr2;
      5'b11010: return {8'h00, mHigh};
      default:  return extData;
    endcase
  endfunction

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1 reset state
    check("R1 addr", addrBus, 24'h0);
    check("R1 ir", {8'h0, instrWord}, 24'h0);
    drive(1, 5'b00001); #2; check("R1 sp", {8'h0, dataBus}, 24'hFFFF);
    drive(1, 5'b11001); #2; check("R1 ir2", {8'h0, dataBus}, 24'h0);
    drive(1, 5'b00001); loadAddrLo = 1; step();
    check("R1 R4 page FF", addrBus, 24'hFFFFFF);

    // R5 / R6 capture of the second instruction word
    memRdData = 16'hA5C3; memHit = 1;
    drive(1, 5'b11000); #2; check("R5 bus", {8'h0, dataBus}, 24'hA5C3);
    step();
    drive(1, 5'b11001); #2; check("R6 ir2", {8'h0, dataBus}, 24'hA5C3);
    // R9 miss reads zero, also for capture
    memHit = 0;
    drive(1, 5'b11111); #2; check("R9 miss", {8'h0, dataBus}, 24'h0);
    drive(1, 5'b11000); #2; check("R9 miss cap bus", {8'h0, dataBus}, 24'h0);
    step();
    drive(1, 5'b11001); #2; check("R5 R9 ir2 zero", {8'h0, dataBus}, 24'h0);
    memHit = 1; memRdData = 16'h1234;
    drive(1, 5'b11111); #2; check("R9 hit", {8'h0, dataBus}, 24'h1234);
    drive(1, 5'b11000); step();

    // R3 / R7 address registers
    extData = 16'hABCD;
    drive(1, 5'b00010); loadAddrHi = 1; step();
    check("R3 high byte", {16'h0, addrBus[23:16]}, 24'hCD);
    drive(1, 5'b11010); #2; check("R7 high out", {8'h0, dataBus}, 24'h00CD);
    extData = 16'h5678;
    drive(1, 5'b00100); loadAddrLo = 1; step();
    check("R3 full addr", addrBus, 24'hCD5678);

    // R8 page load, R4 substitution overrides loadAddrHi
    memRdData = 16'h7E42;
    drive(1, 5'b11011); #2; check("R8 bus", {8'h0, dataBus}, 24'h7E42);
    step();
    drive(1, 5'b00001); loadAddrLo = 1; loadAddrHi = 1; step();
    check("R4 R8 paged addr", addrBus, 24'h42FFFF);

    // R10 stack pointer
    drive(1, 5'b00001); spInc = 1; step();
    #2; check("R10 wrap up", {8'h0, dataBus}, 24'h0000);
    drive(1, 5'b00001); spDec = 1; step();
    #2; check("R10 wrap down", {8'h0, dataBus}, 24'hFFFF);
    drive(1, 5'b00001); spInc = 1; spDec = 1; step();
    #2; check("R10 both", {8'h0, dataBus}, 24'hFFFF);
    drive(1, 5'b00001); spDec = 1; step();
    drive(1, 5'b00001); spDec = 1; step();
    #2; check("R10 dec2", {8'h0, dataBus}, 24'hFFFD);

    // R12 primary instruction word
    extData = 16'hBEEF;
    drive(1, 5'b00011); irLoad = 1; step();
    check("R12 ir", {8'h0, instrWord}, 24'hBEEF);

    // R2 sweep with enable low
    for (int c = 0; c < 32; c++) begin
      drive(0, c[4:0]); #2;
      check("R2 idle", {8'h0, dataBus}, 24'h0);
      step();
    end

    // Full sweep, R5 R6 R7 R8 R9 R10 R11
    mIr2 = 16'h1234; mPage = 8'h42; mHigh = 8'h42; mSp = 16'hFFFD;
    memRdData = 16'h9966; extData = 16'h3C3C;
    for (int c = 0; c < 32; c++) begin
      drive(1, c[4:0]); #2;
      check("R11 sweep", {8'h0, dataBus}, {8'h0, expBus(c[4:0])});
      step();
      if (c[4:0] == 5'b11000) mIr2 = 16'h9966;
      if (c[4:0] == 5'b11011) mPage = 8'h66;
    end
    // R8 page from sweep
    drive(1, 5'b00001); loadAddrLo = 1; step();
    check("R8 swept page", addrBus, {mPage, mSp});

    drive(0, 5'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule